// File: doc/BRIEF.md
# Privileged Shadow Register Restore Unit

This execute-stage unit watches the instruction word of the current slot for a small set of special operations. Four of them sit in encoding space that no ordinary instruction uses; the fifth is an ordinary return that runs without the copy. The main job is to move seven saved shadow values back into a fixed, non-contiguous set of general registers. All seven writes happen in a single cycle. The unit also raises halt and reset requests, and it signals returns from interrupt. One variant of the return first performs the register copy and then signals the return.

Every one of these operations is privileged. Privilege level 0 is the most privileged level. At any other level the unit raises a privileged-operation exception and changes no architectural state. A nullified slot suppresses every effect, including that exception. The register file, the shadow storage and instruction fetch all live outside the unit. The shadow values arrive on a flat input bus, and the unit drives seven write lanes that go to the register file.

Top module: `shadow_restore_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every write enable, halt_req_o, reset_req_o, ret_o and priv_exc_o is low, and gpr_wdata_o is zero.
- R2: The word 32'hFFFDEAD2, presented at privilege 0 in a slot that is not nullified, raises all seven bits of gpr_we_o in the next cycle. Lane k (k = 0..6) carries data bits [32k+31:32k] of shadow_i as sampled with the instruction. Its target register index sits in gpr_waddr_o bits [5k+4:5k] and is 1, 8, 9, 16, 17, 24 and 25 for lanes 0 to 6.
- R3: gpr_we_o is either all zero or all ones in every cycle, so no partial restore is ever visible. When it is all zero, gpr_wdata_o is zero.
- R4: At privilege 0, 32'hFFFDEAD0 pulses halt_req_o and 32'hFFFDEAD1 pulses reset_req_o. Each pulse lasts one cycle, starts in the next cycle, and comes with no register write.
- R5: A return-with-restore word has bits [31:26] = 0, bits [12:5] = 8'h65 and bits [4:0] = 0; bits [25:13] are ignored. At privilege 0 it performs the R2 copy in the next cycle, and ret_o pulses for one cycle in the cycle after the copy.
- R6: A plain return word has bits [31:26] = 0, bits [12:5] = 8'h60 and bits [4:0] = 0; bits [25:13] are ignored. At privilege 0 it pulses ret_o two cycles after the word is presented and writes no register.
- R7: When any of the five words above arrives with priv_i not equal to 0, priv_exc_o pulses in the next cycle. No write, halt, reset or return follows from that word.
- R8: When nullify_i is high, the word in that slot has no effect at all: no write, no halt, no reset, no return and no exception.
- R9: Any word that matches none of the five encodings exactly leaves every output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word of the current slot |
| priv_i | input | 2 | Current privilege level, 0 most privileged |
| nullify_i | input | 1 | The current slot is nullified |
| shadow_i | input | 224 | Seven shadow values, entry k at bits [32k+31:32k] |
| gpr_we_o | output | 7 | Per-lane register write enable |
| gpr_waddr_o | output | 35 | Per-lane target register index, lane k at [5k+4:5k] |
| gpr_wdata_o | output | 224 | Per-lane write data, lane k at [32k+31:32k] |
| halt_req_o | output | 1 | Halt request pulse |
| reset_req_o | output | 1 | Reset request pulse |
| ret_o | output | 1 | Return-from-interrupt strobe |
| priv_exc_o | output | 1 | Privileged-operation exception pulse |

## Verification
The assertions watch several properties on every cycle. The write enables must be all set or all clear. An exception must never coincide with a write, halt or reset. A nullified slot must produce no effect. A privileged word at a lower level must trap, and a return-with-restore must yield its copy followed by its strobe. Other behaviour can only be shown by the bench's scenarios. These are the exact lane-to-register mapping, data captured per lane from a specific shadow pattern, and back-to-back restores with different data. The bench also covers near-miss encodings and ignored field bits, each checked against a model that the bench builds itself.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned PRIV_W   = 2;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned NLANE    = 7;

  localparam logic [INSTR_W-1:0] ENC_HALT    = 32'hFFFD_EAD0;
  localparam logic [INSTR_W-1:0] ENC_RESET   = 32'hFFFD_EAD1;
  localparam logic [INSTR_W-1:0] ENC_RESTORE = 32'hFFFD_EAD2;
  localparam logic [7:0]         RET_SUB     = 8'h60;
  localparam logic [7:0]         RET_RS_SUB  = 8'h65;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_HALT,
    OP_RESET,
    OP_RESTORE,
    OP_RET,
    OP_RET_RESTORE
  } sru_op_e;

  // fixed destination of each shadow lane
  function automatic logic [RIDX_W-1:0] lane_target(input int unsigned k);
    case (k)
      0:       lane_target = RIDX_W'(1);
      1:       lane_target = RIDX_W'(8);
      2:       lane_target = RIDX_W'(9);
      3:       lane_target = RIDX_W'(16);
      4:       lane_target = RIDX_W'(17);
      5:       lane_target = RIDX_W'(24);
      default: lane_target = RIDX_W'(25);
    endcase
  endfunction
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output sru_op_e            op_o
);
  logic ret_shape;

  // return family: major opcode 0, sub-op in [12:5], low field 0
  assign ret_shape = (instr_i[31:26] == 6'd0) && (instr_i[4:0] == 5'd0);

  always_comb begin
    op_o = OP_NONE;
    if (instr_i == ENC_HALT)                               op_o = OP_HALT;
    else if (instr_i == ENC_RESET)                         op_o = OP_RESET;
    else if (instr_i == ENC_RESTORE)                       op_o = OP_RESTORE;
    else if (ret_shape && instr_i[12:5] == RET_RS_SUB)     op_o = OP_RET_RESTORE;
    else if (ret_shape && instr_i[12:5] == RET_SUB)        op_o = OP_RET;
  end
endmodule

// File: rtl/sru_lanes.sv
module sru_lanes
  import sru_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       copy_i,
  input  logic [NLANE*DATA_W-1:0]    shadow_i,
  output logic [NLANE-1:0]           we_o,
  output logic [NLANE*RIDX_W-1:0]    waddr_o,
  output logic [NLANE*DATA_W-1:0]    wdata_o
);
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic              we_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        we_q   <= 1'b0;
        data_q <= '0;
      end else begin
        we_q   <= copy_i;
        data_q <= copy_i ? shadow_i[k*DATA_W +: DATA_W] : '0;
      end
    end

    assign we_o[k]                     = we_q;
    assign wdata_o[k*DATA_W +: DATA_W] = data_q;
    assign waddr_o[k*RIDX_W +: RIDX_W] = lane_target(k);
  end
endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl
  import sru_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sru_op_e op_i,
  input  logic    exec_i,
  input  logic    legal_i,
  output logic    copy_o,
  output logic    halt_o,
  output logic    reset_o,
  output logic    ret_o,
  output logic    exc_o
);
  logic go, ret_s1_q, halt_q, reset_q, ret_q, exc_q;

  assign go     = exec_i && legal_i && (op_i != OP_NONE);
  assign copy_o = go && (op_i == OP_RESTORE || op_i == OP_RET_RESTORE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q   <= 1'b0;
      reset_q  <= 1'b0;
      exc_q    <= 1'b0;
      ret_s1_q <= 1'b0;
      ret_q    <= 1'b0;
    end else begin
      halt_q   <= go && (op_i == OP_HALT);
      reset_q  <= go && (op_i == OP_RESET);
      exc_q    <= exec_i && !legal_i && (op_i != OP_NONE);
      // return trails the copy stage by one cycle
      ret_s1_q <= go && (op_i == OP_RET || op_i == OP_RET_RESTORE);
      ret_q    <= ret_s1_q;
    end
  end

  assign halt_o  = halt_q;
  assign reset_o = reset_q;
  assign exc_o   = exc_q;
  assign ret_o   = ret_q;
endmodule

// File: rtl/shadow_restore_unit.sv
module shadow_restore_unit
  import sru_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = NLANE * DATA_W,
  localparam int unsigned AD_W  = NLANE * RIDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [PRIV_W-1:0]  priv_i,
  input  logic               nullify_i,
  input  logic [SH_W-1:0]    shadow_i,
  output logic [NLANE-1:0]   gpr_we_o,
  output logic [AD_W-1:0]    gpr_waddr_o,
  output logic [SH_W-1:0]    gpr_wdata_o,
  output logic               halt_req_o,
  output logic               reset_req_o,
  output logic               ret_o,
  output logic               priv_exc_o
);
  sru_op_e op;
  logic    copy;

  sru_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op)
  );

  sru_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .exec_i  (!nullify_i),
    .legal_i (priv_i == '0),
    .copy_o  (copy),
    .halt_o  (halt_req_o),
    .reset_o (reset_req_o),
    .ret_o   (ret_o),
    .exc_o   (priv_exc_o)
  );

  sru_lanes #(.DATA_W(DATA_W)) u_lanes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .copy_i   (copy),
    .shadow_i (shadow_i),
    .we_o     (gpr_we_o),
    .waddr_o  (gpr_waddr_o),
    .wdata_o  (gpr_wdata_o)
  );
endmodule

// File: rtl/sru_checker.sv
module sru_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic [1:0]  priv_i,
  input logic        nullify_i,
  input logic [6:0]  gpr_we_o,
  input logic        halt_req_o,
  input logic        reset_req_o,
  input logic        ret_o,
  input logic        priv_exc_o
);
  logic any_priv_word, ret_rs_word;

  assign ret_rs_word   = instr_i[31:26] == 6'd0 && instr_i[4:0] == 5'd0 && instr_i[12:5] == 8'h65;
  assign any_priv_word = ret_rs_word || instr_i == 32'hFFFD_EAD0 || instr_i == 32'hFFFD_EAD1 ||
                         instr_i == 32'hFFFD_EAD2 ||
                         (instr_i[31:26] == 6'd0 && instr_i[4:0] == 5'd0 && instr_i[12:5] == 8'h60);

  AST_ALL_OR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o == 7'h00 || gpr_we_o == 7'h7F); // R3

  AST_TRAP_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_exc_o |-> (gpr_we_o == 7'h00 && !halt_req_o && !reset_req_o)); // R7

  AST_LOW_PRIV_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_priv_word && priv_i != 2'd0 && !nullify_i) |=> priv_exc_o); // R7

  AST_NULLIFIED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nullify_i |=> (gpr_we_o == 7'h00 && !halt_req_o && !reset_req_o && !priv_exc_o)); // R8

  AST_RET_RS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_rs_word && priv_i == 2'd0 && !nullify_i) |=> gpr_we_o == 7'h7F); // R5

  AST_RET_RS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_rs_word && priv_i == 2'd0 && !nullify_i) |=> ##1 ret_o); // R5

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halt_req_o, reset_req_o, priv_exc_o, gpr_we_o[0]})); // R4
endmodule

bind shadow_restore_unit sru_checker u_sru_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .priv_i      (priv_i),
  .nullify_i   (nullify_i),
  .gpr_we_o    (gpr_we_o),
  .halt_req_o  (halt_req_o),
  .reset_req_o (reset_req_o),
  .ret_o       (ret_o),
  .priv_exc_o  (priv_exc_o)
);

// File: tb/shadow_restore_unit_test.sv
`timescale 1ns/1ps
module shadow_restore_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  instr = 32'd0;
  logic [1:0]   priv = 2'd0;
  logic         nul = 1'b0;
  logic [223:0] shadow = '0;
  logic [6:0]   we;
  logic [34:0]  waddr;
  logic [223:0] wdata;
  logic         halt, rst_req, ret, exc;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  shadow_restore_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .priv_i(priv), .nullify_i(nul),
    .shadow_i(shadow), .gpr_we_o(we), .gpr_waddr_o(waddr), .gpr_wdata_o(wdata),
    .halt_req_o(halt), .reset_req_o(rst_req), .ret_o(ret), .priv_exc_o(exc)
  );

  typedef struct {
    logic [6:0]   we;
    logic [223:0] data;
    logic         halt;
    logic         rreq;
    logic         exc;
    logic         ret;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  logic ret_due = 1'b0;
  string ret_tag = "R1";
  logic [34:0] exp_addr;

  initial begin
    int tgt[7] = '{1, 8, 9, 16, 17, 24, 25};
    for (int k = 0; k < 7; k++) exp_addr[k*5 +: 5] = 5'(tgt[k]);
  end

  function automatic exp_t model(input logic [31:0] w, input logic [1:0] p, input logic n,
                                 input logic [223:0] sh, input string tag);
    exp_t e;
    logic is_ret_fam, halt_w, rst_w, res_w, rr_w, r_w, any;
    e.we = '0; e.data = '0; e.halt = 0; e.rreq = 0; e.exc = 0; e.ret = 0; e.tag = tag;
    is_ret_fam = (w[31:26] == 0) && (w[4:0] == 0);
    halt_w = (w == 32'hFFFDEAD0);
    rst_w  = (w == 32'hFFFDEAD1);
    res_w  = (w == 32'hFFFDEAD2);
    rr_w   = is_ret_fam && w[12:5] == 8'h65;
    r_w    = is_ret_fam && w[12:5] == 8'h60;
    any    = halt_w | rst_w | res_w | rr_w | r_w;
    if (!n && any) begin
      if (p != 0) e.exc = 1;
      else begin
        e.halt = halt_w;
        e.rreq = rst_w;
        if (res_w || rr_w) begin e.we = 7'h7F; e.data = sh; end
        e.ret = rr_w | r_w;
      end
    end
    return e;
  endfunction

  // monitor: compares outputs against the oldest queued expectation
  task automatic compare();
    exp_t e;
    if (sb_q.size() == 0) return;
    e = sb_q.pop_front();
    n_vec++;
    if (we !== e.we || wdata !== e.data || halt !== e.halt || rst_req !== e.rreq ||
        exc !== e.exc || (e.we != 0 && waddr !== exp_addr)) begin
      n_bad++;
      $display("FAIL %s: we=%h halt=%b rreq=%b exc=%b addr=%h data=%h expected we=%h halt=%b rreq=%b exc=%b addr=%h data=%h",
               e.tag, we, halt, rst_req, exc, waddr, wdata, e.we, e.halt, e.rreq, e.exc, exp_addr, e.data);
    end
    if (ret !== ret_due) begin
      n_bad++;
      $display("FAIL %s: ret_o=%b expected %b", ret_tag, ret, ret_due);
    end
    ret_due = e.ret;
    ret_tag = e.tag;
  endtask

  // driver: checks the previous slot, then applies the next and queues its expectation
  task automatic apply(input logic [31:0] w, input logic [1:0] p, input logic n,
                       input logic [223:0] sh, input string tag);
    @(negedge clk);
    compare();
    instr = w; priv = p; nul = n; shadow = sh;
    sb_q.push_back(model(w, p, n, sh, tag));
  endtask

  function automatic logic [223:0] pattern(input logic [31:0] seed);
    logic [223:0] v;
    for (int k = 0; k < 7; k++) v[k*32 +: 32] = seed ^ (32'h1111_1111 * (k + 1)) ^ (k << 28);
    return v;
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    n_vec++;
    if (we !== 0 || wdata !== 0 || halt || rst_req || ret || exc) begin
      n_bad++;
      $display("FAIL R1: we=%h halt=%b rreq=%b ret=%b exc=%b expected all zero", we, halt, rst_req, ret, exc);
    end
    rst_n = 1'b1;
    sb_q.push_back(model(32'd0, 0, 0, '0, "R1"));

    apply(32'hFFFDEAD2, 0, 0, pattern(32'hCAFE_0001), "R2");
    apply(32'hFFFDEAD2, 0, 0, pattern(32'h5A5A_7777), "R3");
    apply(32'h0000_0000, 0, 0, pattern(32'h1234_5678), "R3");
    apply(32'hFFFDEAD0, 0, 0, pattern(32'h0), "R4");
    apply(32'hFFFDEAD1, 0, 0, pattern(32'h0), "R4");
    apply(32'hFFFDEAD2, 1, 0, pattern(32'hDEAD_0000), "R7");
    apply(32'hFFFDEAD2, 3, 0, pattern(32'hDEAD_0001), "R7");
    apply(32'hFFFDEAD0, 2, 0, pattern(32'h0), "R7");
    apply({6'd0, 13'h1ABC, 8'h65, 5'd0}, 1, 0, pattern(32'h0), "R7");
    apply(32'hFFFDEAD2, 0, 1, pattern(32'hBEEF_0000), "R8");
    apply(32'hFFFDEAD2, 3, 1, pattern(32'hBEEF_0001), "R8");
    apply({6'd0, 13'h0000, 8'h65, 5'd0}, 0, 1, pattern(32'h0), "R8");
    apply({6'd0, 13'h1FFF, 8'h65, 5'd0}, 0, 0, pattern(32'h7070_0101), "R5");
    apply({6'd0, 13'h0555, 8'h65, 5'd0}, 0, 0, pattern(32'h0F0F_F0F0), "R5");
    apply({6'd0, 13'h0AAA, 8'h60, 5'd0}, 0, 0, pattern(32'hFFFF_FFFF), "R6");
    apply(32'hFFFDEAD2, 0, 0, pattern(32'h0BAD_F00D), "R6");
    apply(32'h0000_0000, 0, 0, pattern(32'h0), "R6");
    apply(32'hFFFDEAD3, 0, 0, pattern(32'h3333_3333), "R9");
    apply(32'h7FFDEAD2, 0, 0, pattern(32'h4444_4444), "R9");
    apply({6'd0, 13'h0000, 8'h65, 5'd1}, 0, 0, pattern(32'h5555_5555), "R9");
    apply({6'd1, 13'h0000, 8'h65, 5'd0}, 0, 0, pattern(32'h6666_6666), "R9");
    apply({6'd0, 13'h0000, 8'h64, 5'd0}, 0, 0, pattern(32'h7777_7777), "R9");
    apply(32'hFFFDEAD2, 0, 0, pattern(32'h9999_0000), "R2");
    apply(32'h0000_0000, 0, 0, '0, "R9");
    apply(32'h0000_0000, 0, 0, '0, "R9");
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule